// File: doc/BRIEF.md
# Timer pin mode and edge interrupt unit

This unit is the pin-side half of one general-purpose timer channel. It owns a single IO pin. A mode register picks what the pin does. In GPIO mode the pin can be an input, or it can be driven low or high, either push-pull or open-drain. In input-capture mode, chosen edges on the pin latch sticky event flags, and these can raise an interrupt. The count engine lives elsewhere. Output-compare and PWM mode values are decoded, but their waveforms come from that count engine, not from this unit.

Software writes the mode word and clears status flags with write-one-to-clear writes to the status word. The status word also shows the synchronized pin level. The pin input passes through a synchronizer, so the unit accepts asynchronous board signals. Capture is active in input-capture mode and in GPIO mode. While edge interrupts are armed (interrupt enable set and an edge selected), GPIO drive requests are ignored and the pin stays an input.

Top module: `tmr_pin_irq`

## Requirements
- R1: After reset the mode word reads 0, the status word reads 0, the pin output enable is low and the interrupt is low.
- R2: A mode write stores only the defined fields (bits 2:0, 5:4, 8, 9, 17:16). Every other bit reads back as 0, so writing all ones reads back 0x00030337.
- R3: The pin select in mode bits 2:0 takes 0 off, 1 capture, 2 compare, 3 PWM and 4 GPIO. Only GPIO (4) can drive the pin. In GPIO mode, bits 5:4 = 00 leave the pin as an input (output enable 0), 10 drives it low and 11 drives it high. In every other mode the output enable is 0.
- R4: With open-drain (mode bit 9) set, a high request releases the pin (output enable 0), while a low request still drives 0.
- R5: Status bit 8 shows the pin level. It follows a change on the pin input in the second clock after the change.
- R6: Edge select is mode bits 17:16: 01 rising, 10 falling, 11 both, 00 none. Capture runs only in mode 1 or 4. A selected edge sets flag bit 0. A selected rising edge also sets bit 1, and a selected falling edge also sets bit 2. A flag becomes visible in the third clock after the pin change.
- R7: A selected edge that arrives while flag bit 0 is already set, and bit 0 is not being cleared in that cycle, sets the overrun flag, bit 3.
- R8: Writing a 1 to a status bit in 3:0 clears that flag. Writing 0 leaves it unchanged.
- R9: When a new edge and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R10: The interrupt output is high exactly while mode bit 8 is set and at least one flag in status bits 3:0 is set.
- R11: While edge interrupts are armed (mode bit 8 set and bits 17:16 nonzero), GPIO drive requests have no effect and the output enable stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeWe | input | 1 | Mode word write strobe |
| modeWdata | input | REG_W | Mode word write data |
| statusWe | input | 1 | Status write strobe (write-one-to-clear) |
| statusWdata | input | REG_W | Status write data; ones in bits 3:0 clear flags |
| modeRdata | output | REG_W | Mode word read value |
| statusRdata | output | REG_W | Flags in 3:0, synchronized pin level in bit 8 |
| pinIn | input | 1 | Asynchronous pin input |
| pinOut | output | 1 | Pin output level |
| pinOe | output | 1 | Pin output enable |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench aims at a clearing write that lands in the same cycle as a fresh edge. A design that lets the clear win would lose that event and read back 0x2 instead of 0x7. It also repeats a rising edge while flag 0 is still pending. A design without the overrun term would miss bit 3. A design that drops the armed-interrupt check would drive the pin during capture. Unselected edges, edge select 00, and the compare mode are all fed with pin toggles and must leave the flags at zero. This catches a design that captures outside modes 1 and 4, or that ignores the edge select. The bench times flag and pin-level checks to the exact clock. A synchronizer with the wrong depth would therefore show up one cycle early or late.

// File: rtl/tpi_pkg.sv
package tpi_pkg;
  // Field positions that software decodes; they must not move.
  localparam int SEL_LSB     = 0;
  localparam int SEL_W       = 3;
  localparam int GPIO_LSB    = 4;
  localparam int IRQ_EN_BIT  = 8;
  localparam int OD_BIT      = 9;
  localparam int EDGE_LSB    = 16;
  localparam int PIN_LVL_BIT = 8;
  localparam int FLAG_W      = 4;

  // Flag slots inside the status word
  localparam int FLG_EVENT   = 0;
  localparam int FLG_RISE    = 1;
  localparam int FLG_FALL    = 2;
  localparam int FLG_OVERRUN = 3;

  typedef enum logic [SEL_W-1:0] {
    PM_OFF     = 3'd0,
    PM_CAPTURE = 3'd1,
    PM_COMPARE = 3'd2,
    PM_PWM     = 3'd3,
    PM_GPIO    = 3'd4
  } pinMode_e;

  typedef struct packed {
    logic              capRise;
    logic              capFall;
    logic              driveEn;
    logic              driveLvl;
    logic              openDrain;
    logic              irqEn;
    logic [FLAG_W-1:0] clrMask;
  } pinStrobe_t;
endpackage

// File: rtl/tpi_ctrl.sv
module tpi_ctrl
  import tpi_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWe,
  input  logic [REG_W-1:0] modeWdata,
  input  logic             statusWe,
  input  logic [REG_W-1:0] statusWdata,
  output logic [REG_W-1:0] modeQ,
  output pinStrobe_t       strb
);
  localparam logic [REG_W-1:0] WR_MASK =
      (REG_W'(7) << SEL_LSB) | (REG_W'(3) << GPIO_LSB) |
      (REG_W'(1) << IRQ_EN_BIT) | (REG_W'(1) << OD_BIT) |
      (REG_W'(3) << EDGE_LSB);

  pinMode_e   pinMode;
  logic [1:0] gpioField;
  logic [1:0] edgeField;
  logic       capActive;
  logic       irqArmed;
  logic       unusedStatusHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= '0;
    else if (modeWe) modeQ <= modeWdata & WR_MASK;
  end

  assign unusedStatusHi = ^statusWdata[REG_W-1:FLAG_W];

  always_comb begin
    pinMode   = pinMode_e'(modeQ[SEL_LSB +: SEL_W]);
    gpioField = modeQ[GPIO_LSB +: 2];
    edgeField = modeQ[EDGE_LSB +: 2];
    irqArmed  = modeQ[IRQ_EN_BIT] && (edgeField != 2'b00);
    case (pinMode)
      PM_CAPTURE, PM_GPIO: capActive = 1'b1;
      PM_COMPARE, PM_PWM:  capActive = 1'b0;
      default:             capActive = 1'b0;
    endcase
  end

  always_comb begin
    strb           = '0;
    strb.capRise   = capActive && edgeField[0];
    strb.capFall   = capActive && edgeField[1];
    strb.driveEn   = (pinMode == PM_GPIO) && gpioField[1] && !irqArmed;
    strb.driveLvl  = gpioField[0];
    strb.openDrain = modeQ[OD_BIT];
    strb.irqEn     = modeQ[IRQ_EN_BIT];
    strb.clrMask   = statusWe ? statusWdata[FLAG_W-1:0] : '0;
  end
endmodule

// File: rtl/tpi_datapath.sv
module tpi_datapath
  import tpi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pinStrobe_t        strb,
  input  logic              pinIn,
  output logic [FLAG_W-1:0] flags,
  output logic              pinLvl,
  output logic              pinOut,
  output logic              pinOe,
  output logic              irqOut
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevLvl;
  logic                   riseHit;
  logic                   fallHit;
  logic                   anyHit;
  logic [FLAG_W-1:0]      setVec;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= pinIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  assign pinLvl = syncQ[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= pinLvl;
  end

  always_comb begin
    riseHit = strb.capRise && pinLvl && !prevLvl;
    fallHit = strb.capFall && !pinLvl && prevLvl;
    anyHit  = riseHit || fallHit;
    setVec              = '0;
    setVec[FLG_EVENT]   = anyHit;
    setVec[FLG_RISE]    = riseHit;
    setVec[FLG_FALL]    = fallHit;
    setVec[FLG_OVERRUN] = anyHit && flags[FLG_EVENT] && !strb.clrMask[FLG_EVENT];
  end

  // New events take priority over same-cycle clears
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~strb.clrMask) | setVec;
  end

  always_comb begin
    pinOe  = strb.driveEn && !(strb.openDrain && strb.driveLvl);
    pinOut = pinOe && strb.driveLvl;
    irqOut = strb.irqEn && (|flags);
  end
endmodule

// File: rtl/tmr_pin_irq.sv
module tmr_pin_irq
  import tpi_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWe,
  input  logic [REG_W-1:0] modeWdata,
  input  logic             statusWe,
  input  logic [REG_W-1:0] statusWdata,
  output logic [REG_W-1:0] modeRdata,
  output logic [REG_W-1:0] statusRdata,
  input  logic             pinIn,
  output logic             pinOut,
  output logic             pinOe,
  output logic             irqOut
);
  pinStrobe_t        strb;
  logic [FLAG_W-1:0] flags;
  logic              pinLvl;

  tpi_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeWdata(modeWdata),
    .statusWe(statusWe), .statusWdata(statusWdata),
    .modeQ(modeRdata), .strb(strb)
  );

  tpi_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pinIn(pinIn),
    .flags(flags), .pinLvl(pinLvl), .pinOut(pinOut),
    .pinOe(pinOe), .irqOut(irqOut)
  );

  always_comb begin
    statusRdata              = '0;
    statusRdata[FLAG_W-1:0]  = flags;
    statusRdata[PIN_LVL_BIT] = pinLvl;
  end
endmodule

// File: rtl/tpi_checker.sv
module tpi_checker #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             statusWe,
  input logic [REG_W-1:0] statusWdata,
  input logic [REG_W-1:0] modeRdata,
  input logic [REG_W-1:0] statusRdata,
  input logic             pinIn,
  input logic             pinOut,
  input logic             pinOe,
  input logic             irqOut
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assert_od_no_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeRdata[9] && pinOe) |-> !pinOut);

  assert_armed_no_drive_R11: assert property (@(posedge clk) disable iff (!rstN)
    (modeRdata[8] && (modeRdata[17:16] != 2'b00)) |-> !pinOe);

  assert_drive_gpio_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeRdata[2:0] != 3'd4) |-> !pinOe);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    !modeRdata[8] |-> !irqOut);

  assert_lvl_delay_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (statusRdata[8] == $past(pinIn, 2)));

  assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(statusRdata[3:0]) &
               ~($past(statusWe) ? $past(statusWdata[3:0]) : 4'h0)) &
               ~statusRdata[3:0]) == 4'h0));
endmodule

bind tmr_pin_irq tpi_checker #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .statusWe(statusWe), .statusWdata(statusWdata),
  .modeRdata(modeRdata), .statusRdata(statusRdata), .pinIn(pinIn),
  .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
);

// File: tb/tb_tmr_pin_irq.sv
`timescale 1ns/1ps
module tb_tmr_pin_irq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeWe = 1'b0;
  logic [31:0] modeWdata = '0;
  logic        statusWe = 1'b0;
  logic [31:0] statusWdata = '0;
  logic [31:0] modeRdata;
  logic [31:0] statusRdata;
  logic        pinIn = 1'b0;
  logic        pinOut;
  logic        pinOe;
  logic        irqOut;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  tmr_pin_irq dut (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeWdata(modeWdata),
    .statusWe(statusWe), .statusWdata(statusWdata), .modeRdata(modeRdata),
    .statusRdata(statusRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeMode(input logic [31:0] v);
    @(negedge clk); modeWe = 1'b1; modeWdata = v;
    @(negedge clk); modeWe = 1'b0;
  endtask

  task automatic writeStatus(input logic [31:0] v);
    @(negedge clk); statusWe = 1'b1; statusWdata = v;
    @(negedge clk); statusWe = 1'b0;
  endtask

  // Change pin, then wait until flags from it are visible (third clock)
  task automatic pinEdge(input logic v);
    @(negedge clk); pinIn = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic tReset;
    chk("R1 mode", modeRdata, 32'h0);
    chk("R1 status", statusRdata, 32'h0);
    chk("R1 oe/irq", {30'h0, pinOe, irqOut}, 32'h0);
  endtask

  task automatic tModeReadback;
    writeMode(32'hFFFF_FFFF);
    chk("R2 masked readback", modeRdata, 32'h0003_0337);
    writeMode(32'h0);
  endtask

  task automatic tGpioDrive;
    writeMode(32'h0000_0024);
    chk("R3 drive low", {30'h0, pinOe, pinOut}, 32'h2);
    writeMode(32'h0000_0034);
    chk("R3 drive high", {30'h0, pinOe, pinOut}, 32'h3);
    writeMode(32'h0000_0004);
    chk("R3 input", {31'h0, pinOe}, 32'h0);
    writeMode(32'h0000_0031);
    chk("R3 capture mode no drive", {31'h0, pinOe}, 32'h0);
    writeMode(32'h0000_0033);
    chk("R3 pwm mode no drive", {31'h0, pinOe}, 32'h0);
  endtask

  task automatic tOpenDrain;
    writeMode(32'h0000_0234);
    chk("R4 od high released", {31'h0, pinOe}, 32'h0);
    writeMode(32'h0000_0224);
    chk("R4 od low driven", {30'h0, pinOe, pinOut}, 32'h2);
  endtask

  task automatic tPinLevel;
    writeMode(32'h0);
    @(negedge clk); pinIn = 1'b1;
    @(negedge clk);
    chk("R5 level not yet", {31'h0, statusRdata[8]}, 32'h0);
    @(negedge clk);
    chk("R5 level after two", {31'h0, statusRdata[8]}, 32'h1);
    pinEdge(1'b0);
  endtask

  task automatic tBothEdges;
    writeStatus(32'hF);
    writeMode(32'h0003_0001);
    @(negedge clk); pinIn = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 flag not before third clock", statusRdata[3:0], 32'h0);
    @(negedge clk);
    chk("R6 rise flags", statusRdata[3:0], 32'h3);
    writeStatus(32'hF);
    pinEdge(1'b0);
    chk("R6 fall flags", statusRdata[3:0], 32'h5);
    writeStatus(32'hF);
  endtask

  task automatic tRiseOverrun;
    writeStatus(32'hF);
    writeMode(32'h0001_0001);
    pinEdge(1'b1);
    chk("R6 rise only", statusRdata[3:0], 32'h3);
    pinEdge(1'b0);
    chk("R6 fall ignored when rise selected", statusRdata[3:0], 32'h3);
    pinEdge(1'b1);
    chk("R7 overrun", statusRdata[3:0], 32'hB);
    writeStatus(32'h9);
    chk("R8 w1c partial", statusRdata[3:0], 32'h2);
    writeStatus(32'h0);
    chk("R8 zero write keeps", statusRdata[3:0], 32'h2);
    writeStatus(32'hF);
    pinEdge(1'b0);
  endtask

  task automatic tFallOnly;
    writeStatus(32'hF);
    writeMode(32'h0002_0004);
    pinEdge(1'b1);
    chk("R6 rise ignored when fall selected", statusRdata[3:0], 32'h0);
    pinEdge(1'b0);
    chk("R6 fall in gpio mode", statusRdata[3:0], 32'h5);
    writeStatus(32'hF);
  endtask

  task automatic tNoCapture;
    writeMode(32'h0000_0001);
    pinEdge(1'b1);
    pinEdge(1'b0);
    chk("R6 edge select none", statusRdata[3:0], 32'h0);
    writeMode(32'h0003_0002);
    pinEdge(1'b1);
    pinEdge(1'b0);
    chk("R6 compare mode no capture", statusRdata[3:0], 32'h0);
  endtask

  task automatic tEdgeWinsClear;
    writeStatus(32'hF);
    writeMode(32'h0003_0001);
    pinEdge(1'b1);
    @(negedge clk); pinIn = 1'b0;
    repeat (2) @(negedge clk);
    statusWe = 1'b1; statusWdata = 32'h5;
    @(negedge clk); statusWe = 1'b0;
    chk("R9 edge beats clear", statusRdata[3:0], 32'h7);
    writeStatus(32'hF);
  endtask

  task automatic tIrq;
    writeStatus(32'hF);
    writeMode(32'h0001_0001);
    pinEdge(1'b1);
    chk("R10 no irq when disabled", {31'h0, irqOut}, 32'h0);
    writeMode(32'h0001_0101);
    chk("R10 irq raised", {31'h0, irqOut}, 32'h1);
    writeStatus(32'hF);
    chk("R10 irq drops on clear", {31'h0, irqOut}, 32'h0);
    pinEdge(1'b0);
  endtask

  task automatic tArmedBlocksDrive;
    writeMode(32'h0001_0134);
    chk("R11 armed blocks drive", {31'h0, pinOe}, 32'h0);
    writeMode(32'h0000_0134);
    chk("R11 drive when not armed", {30'h0, pinOe, pinOut}, 32'h3);
    writeMode(32'h0);
  endtask

  initial begin
    #(5.0 * 20000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tModeReadback();
    tGpioDrive();
    tOpenDrain();
    tPinLevel();
    tBothEdges();
    tRiseOverrun();
    tFallOnly();
    tNoCapture();
    tEdgeWinsClear();
    tIrq();
    tArmedBlocksDrive();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule